// File: doc/BRIEF.md
# Fast PWM Timer with Two Compare Outputs

An 8-bit up-counter with a divide-by-power-of-two prescaler and two compare channels, A and B, that each drive a pulse-width-modulated pin. The counter rises from zero to a ceiling and then returns to zero. The ceiling is either the all-ones count or the active channel-A compare value. Each pin is set or cleared at that return to zero or when the count equals its channel's compare value, according to a two-bit output mode. The pin can also be handed back to a plain port value.

All configuration arrives as static inputs. A two-bit output mode is given per channel. A single bit picks where the ceiling comes from, a three-bit clock select sets the rate, and two compare values are supplied. The compare values pass through shadow registers, so a new duty cycle or period never tears a period in progress. In non-inverting use, a channel with compare value C and ceiling T gives a period of T+1 timer ticks and a high time of C+1 ticks.

Top module: `fpwm_timer`

## Requirements
- R1: The clock select sets the timer tick rate: 3'b001 ticks every clock, and 3'b010, 3'b011, 3'b100 and 3'b101 tick once every 8, 64, 256 and 1024 clocks. The count first advances N clocks after reset is released, so after k clocks it equals floor(k/N) modulo the period.
- R2: Clock select 3'b000 stops the timer, and so do the unused codes 3'b110 and 3'b111. While stopped, the count and both pins hold their values. When ticking resumes, the count continues from the held value.
- R3: On each tick the count rises by one. On the tick where it has reached the ceiling, it returns to zero instead. With the ceiling-select input at 0, the ceiling is 255.
- R4: With the ceiling-select input at 1, the ceiling is the active channel-A compare value, giving a period of that value plus one ticks.
- R5: Each compare value is loaded into its active register while reset is held and on every tick that returns the count to zero, and at no other time. A new value written mid-period first takes effect in the next period.
- R6: Output mode 2'b10 (non-inverting) sets the pin on the tick that returns the count to zero and clears it on the tick where the count equals the compare value. When both happen on one tick, the set wins. From the second period on, the pin is high exactly while count <= compare.
- R7: Output mode 2'b11 (inverting) clears the pin on the return to zero and sets it on a compare match, with the clear winning when both coincide, so the pin is high exactly while count > compare.
- R8: Output mode 2'b00 detaches the pin from the timer. The pin then shows that channel's port-value input, registered, one clock later.
- R9: Output mode 2'b01 on channel A toggles the pin on every compare match when the ceiling-select input is 1, giving a period of twice the ceiling plus one. With the ceiling-select input at 0, and always on channel B, mode 2'b01 behaves as detached (R8).
- R10: Synchronous active-high reset clears the count, both pins and the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_sel | input | 3 | Tick rate select (R1, R2) |
| top_from_a | input | 1 | 1: ceiling is active channel-A compare value; 0: ceiling is 255 |
| out_mode_a | input | 2 | Output mode of channel A |
| out_mode_b | input | 2 | Output mode of channel B |
| cmp_a | input | 8 | Channel-A compare value (buffered) |
| cmp_b | input | 8 | Channel-B compare value (buffered) |
| port_a | input | 1 | Level shown on pin A when detached |
| port_b | input | 1 | Level shown on pin B when detached |
| pwm_a | output | 1 | Channel-A waveform pin |
| pwm_b | output | 1 | Channel-B waveform pin |
| count | output | 8 | Current timer count |

## Verification
The assertions treat the ceiling-select input as steady between resets. If it flips while the count is above the new ceiling, the count is forced to zero on the next tick, and that jump falls outside the stepping property. The stimulus changes the ceiling select and the output modes only while reset is held, or, in the detach scenario, among modes that leave the pin on its port value. The clock select and the compare values are changed at falling edges mid-run to exercise stopping and the shadow registers.

// File: rtl/fpwm_pkg.sv
`timescale 1ns/1ps
package fpwm_pkg;

  typedef enum logic [1:0] {
    OUT_DETACH   = 2'b00,
    OUT_ALT      = 2'b01,
    OUT_CLR_HIT  = 2'b10,
    OUT_SET_HIT  = 2'b11
  } out_mode_e;

  localparam int NUM_TAPS = 5;

  // log2 of the divide ratio selected by clock-select codes 1..5
  function automatic int tap_shift(input int idx);
    case (idx)
      0:       return 0;
      1:       return 3;
      2:       return 6;
      3:       return 8;
      default: return 10;
    endcase
  endfunction

  localparam int DIV_BITS = tap_shift(NUM_TAPS - 1);

endpackage

// File: rtl/fpwm_prescale.sv
`timescale 1ns/1ps
module fpwm_prescale
  import fpwm_pkg::*;
#(
  parameter int DIV_W = DIV_BITS
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] sel,
  output logic       tick
);

  logic [DIV_W-1:0]    div_q;
  logic [NUM_TAPS-1:0] hit;

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else     div_q <= div_q + 1'b1;
  end

  for (genvar gi = 0; gi < NUM_TAPS; gi++) begin : g_tap
    localparam int SH = tap_shift(gi);
    if (SH == 0) begin : g_pass
      assign hit[gi] = 1'b1;
    end else begin : g_div
      assign hit[gi] = &div_q[SH-1:0];
    end
  end

  always_comb begin
    case (sel)
      3'd1:    tick = hit[0];
      3'd2:    tick = hit[1];
      3'd3:    tick = hit[2];
      3'd4:    tick = hit[3];
      3'd5:    tick = hit[4];
      default: tick = 1'b0;
    endcase
  end

  // R1: a divided tap is a single-cycle enable
  p_tick_single_r1: assert property (@(posedge clk) disable iff (rst)
    (tick && sel != 3'd1) |=> (!tick || sel == 3'd1));

endmodule

// File: rtl/fpwm_counter.sv
`timescale 1ns/1ps
module fpwm_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         top_sel,
  input  logic [W-1:0] cmp_a_in,
  input  logic [W-1:0] cmp_b_in,
  output logic [W-1:0] count,
  output logic [W-1:0] ocr_a,
  output logic [W-1:0] ocr_b,
  output logic         wrap
);

  logic [W-1:0] top;

  always_comb begin
    top  = top_sel ? ocr_a : {W{1'b1}};
    wrap = tick && (count >= top);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      ocr_a <= cmp_a_in;
      ocr_b <= cmp_b_in;
    end else if (tick) begin
      if (wrap) begin
        count <= '0;
        ocr_a <= cmp_a_in;
        ocr_b <= cmp_b_in;
      end else begin
        count <= count + 1'b1;
      end
    end
  end

  // R2: no tick, no movement
  p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(count));

  // R3: a tick below the ceiling steps by one
  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && !wrap) |=> count == $past(count) + 1'b1);

  // R5: shadow registers only change at the return to zero
  p_buffer_at_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> ($stable(ocr_a) && $stable(ocr_b)));

endmodule

// File: rtl/fpwm_channel.sv
`timescale 1ns/1ps
module fpwm_channel
  import fpwm_pkg::*;
#(
  parameter int W         = 8,
  parameter bit IS_CHAN_A = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         bottom,
  input  logic         top_sel,
  input  logic [W-1:0] count,
  input  logic [W-1:0] ocr,
  input  logic [1:0]   mode,
  input  logic         gpio,
  output logic         pin
);

  out_mode_e m;
  logic      hit;
  logic      detached;

  always_comb begin
    m        = out_mode_e'(mode);
    hit      = tick && (count == ocr);
    detached = (m == OUT_DETACH) ||
               ((m == OUT_ALT) && !(IS_CHAN_A && top_sel));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin <= 1'b0;
    end else if (detached) begin
      pin <= gpio;
    end else begin
      case (m)
        OUT_ALT:     if (hit) pin <= ~pin;
        OUT_CLR_HIT: if (bottom) pin <= 1'b1; else if (hit) pin <= 1'b0;
        OUT_SET_HIT: if (bottom) pin <= 1'b0; else if (hit) pin <= 1'b1;
        default:     pin <= pin;
      endcase
    end
  end

  // R6: non-inverting pin goes high at the return to zero
  p_noninv_bottom_r6: assert property (@(posedge clk) disable iff (rst)
    (bottom && m == OUT_CLR_HIT) |=> pin);

  // R7: inverting pin goes low at the return to zero
  p_inv_bottom_r7: assert property (@(posedge clk) disable iff (rst)
    (bottom && m == OUT_SET_HIT) |=> !pin);

  // R8: detached pin follows the port value one clock later
  p_detached_follow_r8: assert property (@(posedge clk) disable iff (rst)
    detached |=> pin == $past(gpio));

  // R9: toggle mode flips on every match
  p_toggle_r9: assert property (@(posedge clk) disable iff (rst)
    (hit && m == OUT_ALT && IS_CHAN_A && top_sel) |=> pin != $past(pin));

endmodule

// File: rtl/fpwm_timer.sv
`timescale 1ns/1ps
module fpwm_timer
  import fpwm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [2:0]   clk_sel,
  input  logic         top_from_a,
  input  logic [1:0]   out_mode_a,
  input  logic [1:0]   out_mode_b,
  input  logic [W-1:0] cmp_a,
  input  logic [W-1:0] cmp_b,
  input  logic         port_a,
  input  logic         port_b,
  output logic         pwm_a,
  output logic         pwm_b,
  output logic [W-1:0] count
);

  logic         tick;
  logic         wrap;
  logic [W-1:0] ocr_a_q;
  logic [W-1:0] ocr_b_q;

  fpwm_prescale #(.DIV_W(DIV_BITS)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .sel  (clk_sel),
    .tick (tick)
  );

  fpwm_counter #(.W(W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .top_sel  (top_from_a),
    .cmp_a_in (cmp_a),
    .cmp_b_in (cmp_b),
    .count    (count),
    .ocr_a    (ocr_a_q),
    .ocr_b    (ocr_b_q),
    .wrap     (wrap)
  );

  fpwm_channel #(.W(W), .IS_CHAN_A(1'b1)) u_ch_a (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .bottom  (wrap),
    .top_sel (top_from_a),
    .count   (count),
    .ocr     (ocr_a_q),
    .mode    (out_mode_a),
    .gpio    (port_a),
    .pin     (pwm_a)
  );

  fpwm_channel #(.W(W), .IS_CHAN_A(1'b0)) u_ch_b (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .bottom  (wrap),
    .top_sel (top_from_a),
    .count   (count),
    .ocr     (ocr_b_q),
    .mode    (out_mode_b),
    .gpio    (port_b),
    .pin     (pwm_b)
  );

  // R10: reset leaves the count and pins at zero
  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (count == '0 && !pwm_a && !pwm_b));

endmodule

// File: tb/fpwm_timer_tb_top.sv
`timescale 1ns/1ps
module fpwm_timer_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] clk_sel = 3'd1;
  logic       top_from_a = 1'b0;
  logic [1:0] out_mode_a = 2'b00;
  logic [1:0] out_mode_b = 2'b00;
  logic [7:0] cmp_a = 8'd0;
  logic [7:0] cmp_b = 8'd0;
  logic       port_a = 1'b0;
  logic       port_b = 1'b0;
  logic       pwm_a;
  logic       pwm_b;
  logic [7:0] count;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  fpwm_timer dut_i (
    .clk        (clk),
    .rst        (rst),
    .clk_sel    (clk_sel),
    .top_from_a (top_from_a),
    .out_mode_a (out_mode_a),
    .out_mode_b (out_mode_b),
    .cmp_a      (cmp_a),
    .cmp_b      (cmp_b),
    .port_a     (port_a),
    .port_b     (port_b),
    .pwm_a      (pwm_a),
    .pwm_b      (pwm_b),
    .count      (count)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      if (n_fail < 40) $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_pin(input int mode, input bit is_a, input bit tsel,
                                 input int kt, input int top, input int o);
    int wraps = kt / (top + 1);
    int cnt   = kt % (top + 1);
    case (mode)
      2:       return (wraps == 0) ? 0 : ((cnt <= o) ? 1 : 0);
      3:       return (cnt > o) ? 1 : 0;
      1:       return (is_a && tsel) ? (wraps % 2) : 0;
      default: return 0;
    endcase
  endfunction

  task automatic do_reset(input int sel, input bit tsel, input int oa, input int ob,
                          input int ma, input int mb);
    @(negedge clk);
    rst = 1'b1; clk_sel = 3'(sel); top_from_a = tsel;
    cmp_a = 8'(oa); cmp_b = 8'(ob); out_mode_a = 2'(ma); out_mode_b = 2'(mb);
    port_a = 1'b0; port_b = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Runs a configuration from reset and checks count and both pins each clock
  task automatic run_model(input string tag, input int sel, input int ndiv, input bit tsel,
                           input int oa, input int ob, input int ma, input int mb,
                           input int cycles);
    int top = tsel ? oa : 255;
    do_reset(sel, tsel, oa, ob, ma, mb);
    chk(count == 0 && !pwm_a && !pwm_b, {tag, " R10 reset state"}, count, 0);
    for (int k = 1; k <= cycles; k++) begin
      int kt;
      @(posedge clk); @(negedge clk);
      kt = k / ndiv;
      chk(count == 8'(kt % (top + 1)), {tag, " R1 R3 R4 count"}, count, kt % (top + 1));
      chk(pwm_a == exp_pin(ma, 1'b1, tsel, kt, top, oa), {tag, " R6 R7 R9 pin A"},
          pwm_a, exp_pin(ma, 1'b1, tsel, kt, top, oa));
      chk(pwm_b == exp_pin(mb, 1'b0, tsel, kt, top, ob), {tag, " R6 R7 pin B"},
          pwm_b, exp_pin(mb, 1'b0, tsel, kt, top, ob));
    end
  endtask

  task automatic t_fixed_top;
    // R3 R6 R7: ceiling 255, A inverting at 191, B non-inverting at 63
    run_model("fixed_top", 1, 1, 1'b0, 191, 63, 3, 2, 768);
  endtask

  task automatic t_top_from_a;
    // R4 R9: ceiling 235 from channel A, A toggles, B non-inverting at 99
    run_model("top_a", 1, 1, 1'b1, 235, 99, 1, 2, 944);
  endtask

  task automatic t_prescale;
    // R1: each divided rate
    run_model("div8",    2, 8,    1'b1, 9, 4, 1, 3, 240);
    run_model("div64",   3, 64,   1'b1, 3, 1, 1, 2, 512);
    run_model("div256",  4, 256,  1'b1, 3, 2, 1, 3, 2048);
    run_model("div1024", 5, 1024, 1'b1, 1, 0, 1, 2, 4096);
  endtask

  task automatic t_full_duty;
    // R6 R7: compare equal to ceiling, set/clear at zero wins
    run_model("full_noninv", 1, 1, 1'b1, 5, 5, 1, 2, 30);
    run_model("full_inv",    1, 1, 1'b1, 5, 5, 1, 3, 30);
    run_model("zero_cmp",    1, 1, 1'b1, 7, 0, 1, 2, 40);
  endtask

  task automatic t_buffer;
    // R5: new ceiling written at count 3 waits for the return to zero
    do_reset(1, 1'b1, 9, 2, 1, 2);
    for (int k = 1; k <= 40; k++) begin
      int e;
      @(posedge clk); @(negedge clk);
      if (k == 3) cmp_a = 8'd4;
      e = (k <= 9) ? k : ((k - 10) % 5);
      chk(count == 8'(e), "R5 shadowed ceiling", count, e);
    end
  endtask

  task automatic t_stop;
    logic [7:0] c;
    logic       pa, pb;
    do_reset(1, 1'b0, 20, 50, 3, 2);
    repeat (100) @(posedge clk);
    @(negedge clk);
    clk_sel = 3'd0;
    c = count; pa = pwm_a; pb = pwm_b;
    chk(c == 8'd100, "R1 count before stop", c, 100);
    repeat (40) @(posedge clk);
    @(negedge clk);
    chk(count == c, "R2 stopped count", count, c);
    chk(pwm_a == pa && pwm_b == pb, "R2 stopped pins", {pwm_a, pwm_b}, {pa, pb});
    clk_sel = 3'd6;
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(count == c, "R2 unused code holds", count, c);
    clk_sel = 3'd1;
    @(posedge clk); @(negedge clk);
    chk(count == c + 8'd1, "R2 resume", count, c + 1);
  endtask

  task automatic t_detach;
    // R8 R9: modes that hand the pin to the port value
    do_reset(1, 1'b0, 2, 3, 1, 1);
    for (int k = 0; k < 20; k++) begin
      port_a = k[0]; port_b = ~k[1];
      @(posedge clk); @(negedge clk);
      chk(pwm_a == k[0], "R9 mode 01 without ceiling select on A", pwm_a, k[0]);
      chk(pwm_b == ~k[1], "R9 mode 01 on B", pwm_b, ~k[1]);
    end
    out_mode_a = 2'b00; out_mode_b = 2'b00;
    for (int k = 0; k < 12; k++) begin
      port_a = k[1]; port_b = k[0];
      @(posedge clk); @(negedge clk);
      chk(pwm_a == k[1], "R8 detached A", pwm_a, k[1]);
      chk(pwm_b == k[0], "R8 detached B", pwm_b, k[0]);
    end
  endtask

  initial begin
    t_fixed_top();
    t_top_from_a();
    t_prescale();
    t_full_duty();
    t_buffer();
    t_stop();
    t_detach();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL R3 watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule